// File: doc/BRIEF.md
# GPU Command Packet Framer

The framer takes a stream of 32-bit command words over a valid/ready handshake. It marks where each graphics command packet starts and ends. The top byte of the first word is the opcode. For most opcodes a fixed count of extra words follows, set by the opcode. Two polyline opcode groups have a variable length and end on a terminator word. Each accepted command word is echoed on a registered packet output with start and end markers, so a rasteriser downstream can collect whole packets.

Opcodes 0xA0 to 0xDF are rectangle copies. Each has a three-word header: the opcode, a position and a size. A read copy (the opcode's top three bits equal 110) is framed and then the framer returns to command mode. A write copy moves the framer into a pixel-streaming state. Each later data word holds two 16-bit pixels, low half first. The framer turns them into writes on a one-pixel-per-cycle VRAM write port. The pixels walk the rectangle row by row, and the column is kept across word boundaries. A busy flag covers the whole stream.

Environment opcodes 0xE0 to 0xE7 are single-word packets. Two of them also load the status output.

Top module: `gpu_cmd_framer`

## Requirements
- R1: A packet starts on an opcode word (out_sop=1) and ends 1+N words later (out_eop=1 on the last word). N is 2 for 0x02. For 0x20-0x3F, N is 3, 6, 4, 8, 5, 8, 7 or 11 for the groups of four starting at 0x20, 0x24, ..., 0x3C. N is 2 for 0x40-0x47, 3 for 0x50-0x57, 2/3/1 for 0x60/0x64/0x68 groups, 1/2/1/2 for the 0x70/0x74/0x78/0x7C groups, and 3 for 0x80.
- R2: Every opcode with N=0 that is not a polyline or a copy is a one-word packet: out_sop and out_eop are both 1 on that word. Examples are 0x00, 0x6C-0x6F and 0xE0-0xE7.
- R3: A flat polyline (0x48-0x4F) always includes word indices 1 and 2. From index 3 on, it ends at the first word w where (w & 0xF000F000) == 0x50005000.
- R4: A shaded polyline (0x58-0x5F) tests only the even indices 4, 6, 8, and so on for the terminator pattern. A matching word at an odd index, or at an index below 4, does not end the packet.
- R5: A copy opcode (0xA0-0xDF) frames a three-word packet: opcode, position, size. For a read copy (opcode[7:5]=110) no pixel writes follow, busy stays 0, and the next word is handled as an opcode.
- R6: For a copy, X is position[9:0] and Y is position[24:16]. The width is ((size[9:0]-1) mod 1024)+1 and the height is ((size[24:16]-1) mod 512)+1. A zero field therefore gives 1024 or 512, and size bits outside these fields are ignored.
- R7: During a write copy, each data word gives two pixels: bits [15:0] first, then bits [31:16]. Pixel p goes to address (Y + p/width)*1024 + (X + p mod width), with both coordinates taken modulo their field size. Data words never appear on the packet output.
- R8: Pixels past width*height in the last data word are dropped. The word after the last data word is decoded as an opcode.
- R9: busy rises on the cycle the size word of a write copy is framed. It falls together with the write of the last pixel.
- R10: During a write copy, in_ready drops for exactly one cycle after each data word whose high pixel is still needed. in_ready is never low outside a write copy.
- R11: Word 0xE1xxxxxx loads status[10:0] from bits [10:0]. Word 0xE6xxxxxx loads status[12:11] from bits [1:0]. Other words leave status unchanged.
- R12: After reset: busy=0, status=0, out_valid=0, vram_we=0 and in_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command word offered |
| in_ready | output | 1 | Framer can take a word |
| in_data | input | 32 | Command or pixel data word |
| out_valid | output | 1 | Framed command word present |
| out_data | output | 32 | Framed command word |
| out_sop | output | 1 | First word of a packet |
| out_eop | output | 1 | Last word of a packet |
| vram_we | output | 1 | Pixel write strobe |
| vram_addr | output | 19 | Pixel address, row*1024+column |
| vram_data | output | 16 | Pixel value |
| busy | output | 1 | Write copy in progress |
| status | output | 13 | Mirrored environment bits |

## Verification
The fixed-length opcodes are spread across several table groups so that one misplaced length entry shows up as a shifted end marker. Each polyline carries terminator patterns at positions where they must be ignored: index 2 for the flat form, and odd indices for the shaded form. This separates a search that starts too early, or checks the wrong parity, from a correct one. Write copies use an odd width, a width with garbage in the unused size bits, and a zero height field. These cases expose column carry across words, the dropped trailing pixel and the minus-one/plus-one field wrap. Read copies and environment words run between the copies to show that command mode resumes cleanly.

// File: rtl/gpu_cmd_framer.sv
module gpu_cmd_framer #(
  parameter int XW = 10,
  parameter int YW = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_data,
  output logic             out_valid,
  output logic [31:0]      out_data,
  output logic             out_sop,
  output logic             out_eop,
  output logic             vram_we,
  output logic [XW+YW-1:0] vram_addr,
  output logic [15:0]      vram_data,
  output logic             busy,
  output logic [12:0]      status
);
  localparam int WW = XW + 1;
  localparam int HW = YW + 1;

  typedef enum logic [2:0] {S_OP, S_FIX, S_POLY, S_CPY, S_PIX} st_t;

  st_t            st;
  logic [3:0]     rem;
  logic           shaded, ph, cp_rd, pend;
  logic [15:0]    hi;
  logic [XW-1:0]  x0, col;
  logic [YW-1:0]  y0, row;
  logic [WW-1:0]  wid;
  logic [HW-1:0]  hleft;

  function automatic logic [3:0] ext_len(input logic [7:0] op);
    logic [3:0] n;
    n = 4'd0;
    if (op == 8'h02 || op == 8'h80) n = (op == 8'h02) ? 4'd2 : 4'd3;
    else begin
      case (op[7:2])
        6'h08: n = 4'd3;
        6'h09: n = 4'd6;
        6'h0A: n = 4'd4;
        6'h0B: n = 4'd8;
        6'h0C: n = 4'd5;
        6'h0D: n = 4'd8;
        6'h0E: n = 4'd7;
        6'h0F: n = 4'd11;
        6'h10, 6'h11: n = 4'd2;
        6'h14, 6'h15: n = 4'd3;
        6'h18: n = 4'd2;
        6'h19: n = 4'd3;
        6'h1A: n = 4'd1;
        6'h1C: n = 4'd1;
        6'h1D: n = 4'd2;
        6'h1E: n = 4'd1;
        6'h1F: n = 4'd2;
        default: n = 4'd0;
      endcase
    end
    return n;
  endfunction

  wire [7:0] op       = in_data[31:24];
  wire       acc      = in_valid && in_ready;
  wire       is_copy  = (op >= 8'hA0) && (op <= 8'hDF);
  wire       is_pflat = (op[7:3] == 5'b01001);
  wire       is_pshd  = (op[7:3] == 5'b01011);
  wire [3:0] ext      = ext_len(op);
  wire       term     = (in_data & 32'hF000F000) == 32'h50005000;

  wire [XW-1:0] wm1 = in_data[XW-1:0] - XW'(1);
  wire [YW-1:0] hm1 = in_data[16+YW-1:16] - YW'(1);

  wire col_last = ({1'b0, col} + WW'(1)) == wid;
  wire pix_step = (st == S_PIX) && (pend || acc);

  logic eop_c;
  always_comb begin
    case (st)
      S_OP:    eop_c = !is_copy && !is_pflat && !is_pshd && (ext == 4'd0);
      S_FIX:   eop_c = (rem == 4'd1);
      S_POLY:  eop_c = (rem == 4'd0) && (!shaded || !ph) && term;
      S_CPY:   eop_c = (rem == 4'd1);
      default: eop_c = 1'b0;
    endcase
  end

  assign in_ready = !((st == S_PIX) && pend);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_OP; rem <= '0; shaded <= 1'b0; ph <= 1'b0; cp_rd <= 1'b0;
      pend <= 1'b0; hi <= '0; x0 <= '0; y0 <= '0; col <= '0; row <= '0;
      wid <= '0; hleft <= '0; busy <= 1'b0; status <= '0;
      out_valid <= 1'b0; out_data <= '0; out_sop <= 1'b0; out_eop <= 1'b0;
      vram_we <= 1'b0; vram_addr <= '0; vram_data <= '0;
    end else begin
      out_valid <= 1'b0;
      vram_we   <= 1'b0;
      if (acc && st != S_PIX) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
        out_sop   <= (st == S_OP);
        out_eop   <= eop_c;
      end
      case (st)
        S_OP: if (acc) begin
          if (is_copy) begin
            st <= S_CPY; rem <= 4'd2; cp_rd <= (op[7:5] == 3'b110);
          end else if (is_pflat || is_pshd) begin
            st <= S_POLY; rem <= is_pshd ? 4'd3 : 4'd2; shaded <= is_pshd; ph <= 1'b0;
          end else if (ext != 4'd0) begin
            st <= S_FIX; rem <= ext;
          end
          if (op[7:3] == 5'b11100) begin
            if (op[2:0] == 3'd1) status[10:0]  <= in_data[10:0];
            if (op[2:0] == 3'd6) status[12:11] <= in_data[1:0];
          end
        end
        S_FIX: if (acc) begin
          rem <= rem - 4'd1;
          if (rem == 4'd1) st <= S_OP;
        end
        S_POLY: if (acc) begin
          if (rem != 4'd0) begin
            rem <= rem - 4'd1; ph <= 1'b0;
          end else if (eop_c) st <= S_OP;
          else ph <= ~ph;
        end
        S_CPY: if (acc) begin
          rem <= rem - 4'd1;
          if (rem == 4'd2) begin
            x0 <= in_data[XW-1:0];
            y0 <= in_data[16+YW-1:16];
          end else begin
            wid <= {1'b0, wm1} + WW'(1);
            hleft <= {1'b0, hm1} + HW'(1);
            col <= '0; row <= '0; pend <= 1'b0;
            if (cp_rd) st <= S_OP;
            else begin st <= S_PIX; busy <= 1'b1; end
          end
        end
        S_PIX: if (pix_step) begin
          vram_we   <= 1'b1;
          vram_addr <= {y0 + row, x0 + col};
          vram_data <= pend ? hi : in_data[15:0];
          if (pend) pend <= 1'b0;
          else begin pend <= 1'b1; hi <= in_data[31:16]; end
          if (col_last) begin
            col <= '0; row <= row + YW'(1); hleft <= hleft - HW'(1);
            if (hleft == HW'(1)) begin
              st <= S_OP; busy <= 1'b0; pend <= 1'b0;
            end
          end else col <= col + XW'(1);
        end
        default: st <= S_OP;
      endcase
    end
  end

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (out_valid && out_eop));
  // R9
  write_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vram_we |-> $past(busy));
  // R10
  single_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);
  // R10
  stall_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> busy);
  // R7
  pix_not_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vram_we |-> !out_valid);
endmodule

// File: tb/sim_gpu_cmd_framer.sv
module sim_gpu_cmd_framer;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic in_ready, out_valid, out_sop, out_eop, vram_we, busy;
  logic [31:0] out_data;
  logic [18:0] vram_addr;
  logic [15:0] vram_data;
  logic [12:0] status;

  int checks = 0, errors = 0;
  logic [33:0] pq[$];
  string       ptag[$];
  logic [34:0] vq[$];
  string       vtag[$];

  always #(CLK_NS/2) clk = ~clk;

  gpu_cmd_framer u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .vram_we(vram_we),
    .vram_addr(vram_addr), .vram_data(vram_data), .busy(busy), .status(status)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (out_valid) begin
      if (pq.size() == 0) chk(1'b0, "R1", "unexpected packet word", {out_sop, out_eop, out_data}, 0);
      else begin
        logic [33:0] e;
        string t;
        e = pq.pop_front();
        t = ptag.pop_front();
        chk({out_sop, out_eop, out_data} == e, t, "packet word", {out_sop, out_eop, out_data}, e);
      end
    end
    if (vram_we) begin
      if (vq.size() == 0) chk(1'b0, "R8", "unexpected pixel write", {vram_addr, vram_data}, 0);
      else begin
        logic [34:0] e;
        string t;
        e = vq.pop_front();
        t = vtag.pop_front();
        chk({vram_addr, vram_data} == e, t, "pixel write", {vram_addr, vram_data}, e);
      end
    end
  end

  task automatic send(input logic [31:0] d);
    in_valid = 1'b1;
    in_data  = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pkt(input logic [31:0] d, input bit s, input bit e, input string t);
    pq.push_back({s, e, d});
    ptag.push_back(t);
    send(d);
  endtask

  task automatic fixed(input logic [7:0] op, input int n, input string t);
    pkt({op, 24'h123456}, 1'b1, n == 0, t);
    for (int i = 1; i <= n; i++) pkt(32'h0000_1000 + i, 1'b0, i == n, t);
  endtask

  task automatic copy_wr(input logic [31:0] pos, input logic [31:0] sz,
                         input int base, input string t);
    int wv, hv, npx, nw, x, y;
    wv = (((sz & 32'h3FF) - 1) & 32'h3FF) + 1;
    hv = ((((sz >> 16) & 32'h1FF) - 1) & 32'h1FF) + 1;
    x = pos & 32'h3FF;
    y = (pos >> 16) & 32'h1FF;
    npx = wv * hv;
    nw = (npx + 1) / 2;
    pkt(32'hA000_0000, 1'b1, 1'b0, "R5");
    pkt(pos, 1'b0, 1'b0, "R5");
    pkt(sz, 1'b0, 1'b1, "R5");
    chk(busy == 1'b1, "R9", "busy after header", busy, 1);
    for (int k = 0; k < nw; k++) begin
      logic [15:0] lo, hv16;
      lo = 16'(base + 2 * k);
      hv16 = 16'(base + 2 * k + 1);
      for (int p = 2 * k; p < 2 * k + 2; p++) if (p < npx) begin
        vq.push_back({9'((y + p / wv) % 512), 10'((x + p % wv) % 1024), 16'(base + p)});
        vtag.push_back(t);
      end
      send({hv16, lo});
      if (k == 0 && npx >= 2) chk(in_ready == 1'b0, "R10", "stall for high pixel", in_ready, 0);
    end
    @(negedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R9", "busy after last pixel", busy, 0);
    chk(vq.size() == 0, "R7", "pixels pending", vq.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12
    chk(busy == 1'b0, "R12", "busy", busy, 0);
    chk(status == 13'h0, "R12", "status", status, 0);
    chk(out_valid == 1'b0 && vram_we == 1'b0, "R12", "strobes", {out_valid, vram_we}, 0);
    chk(in_ready == 1'b1, "R12", "in_ready", in_ready, 1);

    fixed(8'h02, 2, "R1");
    fixed(8'h21, 3, "R1");
    fixed(8'h26, 6, "R1");
    fixed(8'h2B, 4, "R1");
    fixed(8'h2C, 8, "R1");
    fixed(8'h33, 5, "R1");
    fixed(8'h37, 8, "R1");
    fixed(8'h38, 7, "R1");
    fixed(8'h3F, 11, "R1");
    fixed(8'h44, 2, "R1");
    fixed(8'h52, 3, "R1");
    fixed(8'h60, 2, "R1");
    fixed(8'h65, 3, "R1");
    fixed(8'h6A, 1, "R1");
    fixed(8'h71, 1, "R1");
    fixed(8'h76, 2, "R1");
    fixed(8'h7B, 1, "R1");
    fixed(8'h7C, 2, "R1");
    fixed(8'h80, 3, "R1");
    fixed(8'h00, 0, "R2");
    fixed(8'h6D, 0, "R2");
    fixed(8'h90, 0, "R2");

    // R3: terminator at index 3 ends at once
    pkt(32'h4800_00FF, 1'b1, 1'b0, "R3");
    pkt(32'h0001_0001, 1'b0, 1'b0, "R3");
    pkt(32'h0002_0002, 1'b0, 1'b0, "R3");
    pkt(32'h5555_5555, 1'b0, 1'b1, "R3");
    // R3: pattern at index 2 ignored
    pkt(32'h4C00_00FF, 1'b1, 1'b0, "R3");
    pkt(32'h0001_0001, 1'b0, 1'b0, "R3");
    pkt(32'h5000_5000, 1'b0, 1'b0, "R3");
    pkt(32'h0003_0003, 1'b0, 1'b0, "R3");
    pkt(32'h5FFF_5000, 1'b0, 1'b1, "R3");
    // R4: odd indices and index 3 ignored, ends at index 6
    pkt(32'h5800_0011, 1'b1, 1'b0, "R4");
    pkt(32'h0001_0001, 1'b0, 1'b0, "R4");
    pkt(32'h0022_0033, 1'b0, 1'b0, "R4");
    pkt(32'h5000_5000, 1'b0, 1'b0, "R4");
    pkt(32'h0044_0044, 1'b0, 1'b0, "R4");
    pkt(32'h5123_5456, 1'b0, 1'b0, "R4");
    pkt(32'h5000_5000, 1'b0, 1'b1, "R4");
    fixed(8'h00, 0, "R4");

    // R5: read copy framed, no stream
    pkt(32'hC000_0000, 1'b1, 1'b0, "R5");
    pkt(32'h0010_0020, 1'b0, 1'b0, "R5");
    pkt(32'h0004_0004, 1'b0, 1'b1, "R5");
    chk(busy == 1'b0, "R5", "busy after read copy", busy, 0);
    fixed(8'h20, 3, "R5");

    copy_wr(32'h0005_0100, 32'h0003_0003, 16'h1000, "R7");
    fixed(8'h68, 1, "R8");
    copy_wr(32'h0020_03F0, 32'h0003_FC02, 16'h2000, "R6");
    copy_wr(32'h0000_0007, 32'h0000_0001, 16'h3000, "R6");
    copy_wr(32'h0001_0002, 32'h0001_0005, 16'h4000, "R8");
    fixed(8'h24, 6, "R8");

    // R11
    fixed(8'hE1, 0, "R11");
    pkt(32'hE1AB_CDEF, 1'b1, 1'b1, "R11");
    chk(status == 13'h05EF, "R11", "status after E1", status, 13'h05EF);
    pkt(32'hE6FF_FFFE, 1'b1, 1'b1, "R11");
    chk(status == 13'h15EF, "R11", "status after E6", status, 13'h15EF);
    pkt(32'hE3FF_FFFF, 1'b1, 1'b1, "R11");
    chk(status == 13'h15EF, "R11", "status after E3", status, 13'h15EF);
    pkt(32'hE100_0000, 1'b1, 1'b1, "R11");
    chk(status == 13'h1000, "R11", "status after E1 clear", status, 13'h1000);

    repeat (3) @(negedge clk);
    chk(pq.size() == 0, "R1", "packet words pending", pq.size(), 0);
    chk(vq.size() == 0, "R8", "pixels pending", vq.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R12 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule